// File: doc/BRIEF.md
# Multi-Level Interrupt Priority Evaluator

This block decides which interrupt, if any, the processor should take next. It watches the current processor priority level, a halt request pin, a memory error flag, four banks of 32 hardware request sources (levels 0x14 through 0x17) and a 16-bit software interrupt summary. From these it forms, every cycle and without registers in the path, the single highest level that can be delivered, or 0 when nothing is deliverable.

Hardware requests are held inside the block. Each source is raised by a one-cycle pulse on its own input bit. When the processor acknowledges a hardware level, the block clears the lowest-numbered pending source of that level. One cycle later it returns the interrupt vector programmed for that source. Vectors are loaded through a simple write port, one entry per source.

Top module: `intr_prio_eval`

## Requirements
- R1: While `halt_pin` is 1, `win_level` is 0x1F whatever the current priority and other requests.
- R2: With `halt_pin` at 0 and `mem_err` at 1, `win_level` is 0x1D when `cur_ipl` is below 0x1D. At 0x1D or above the memory error is not delivered.
- R3: Hardware level 0x14+k (k = 0..3) is pending when any of bits k*32 .. k*32+31 of the held request set is 1. Pending levels are scanned from 0x17 down. The highest pending level wins only if it is above `cur_ipl`. When the scan meets a level at or below `cur_ipl` the result is 0, and software requests are not considered.
- R4: Software requests are considered only when no hardware level is pending above `cur_ipl` and `cur_ipl` is below 0xF. Summary bit n stands for level n. Bits numbered at or below `cur_ipl` are ignored, and bit 0 is never delivered.
- R5: Among the eligible software bits, the highest bit number gives `win_level`.
- R6: With no deliverable request, `win_level` is 0.
- R7: When `ack_valid` is 1 with `ack_lvl` = k, on the next cycle `ack_ready` is 1 and `ack_vector` carries the stored vector of the lowest-numbered pending source of level 0x14+k. That source's pending bit is cleared.
- R8: Acknowledging a level with no pending source gives `ack_vector` = 0 on the next cycle and changes no pending state.
- R9: A pulse on `req_set` bit k*32+s makes source s of level 0x14+k pending. If the same bit is cleared by an acknowledge in the same cycle, the set wins and the bit stays pending.
- R10: With `vec_we` at 1, `vec_wdata` is stored as the vector of source `vec_src` of level 0x14+`vec_lvl`. Reset clears all pending bits and all vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_ipl | input | 5 | Current processor priority level |
| halt_pin | input | 1 | Halt request |
| mem_err | input | 1 | Memory error flag |
| sw_summary | input | 16 | Software interrupt summary, bit n = level n |
| req_set | input | 128 | Per-source set pulses, bit k*32+s = source s of level 0x14+k |
| vec_we | input | 1 | Vector write enable |
| vec_lvl | input | 2 | Vector write hardware level index |
| vec_src | input | 5 | Vector write source number |
| vec_wdata | input | 16 | Vector write data |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_lvl | input | 2 | Acknowledged hardware level index |
| win_level | output | 5 | Highest deliverable level, 0 if none |
| ack_ready | output | 1 | Acknowledge result valid, one cycle after `ack_valid` |
| ack_vector | output | 16 | Vector of the acknowledged source, 0 if level was empty |

## Verification
An acknowledge clear and a set pulse can land on the same source bit in the same cycle. The bench provokes this by pulsing a source already pending while acknowledging its level, and again with a different source of the same level. A follow-up acknowledge must still return the re-set source's vector, which judges that the set took precedence over the clear. A scoreboard queue holds the expected vector for each acknowledge, computed from a bench-side model of pending bits, and a monitor compares it when `ack_ready` rises.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int unsigned LVL_W    = 5;
  localparam int unsigned NUM_HW   = 4;
  localparam int unsigned SRCS     = 32;
  localparam int unsigned VEC_W    = 16;
  localparam int unsigned SW_W     = 16;
  localparam int unsigned SRC_W    = $clog2(SRCS);
  localparam int unsigned HW_IDX_W = $clog2(NUM_HW);

  localparam logic [LVL_W-1:0] LVL_HALT    = 5'h1F;
  localparam logic [LVL_W-1:0] LVL_MERR    = 5'h1D;
  localparam logic [LVL_W-1:0] LVL_HW_BASE = 5'h14;

  // index of the lowest set bit of a request word, 0 when empty
  function automatic logic [SRC_W-1:0] lowest_src(input logic [SRCS-1:0] w);
    lowest_src = '0;
    for (int i = SRCS - 1; i >= 0; i--) begin
      if (w[i]) lowest_src = SRC_W'(i);
    end
  endfunction

  // highest software bit strictly above ipl, 0 when none or ipl too high
  function automatic logic [LVL_W-1:0] sw_pick(input logic [LVL_W-1:0] ipl,
                                               input logic [SW_W-1:0] sum);
    sw_pick = '0;
    if (int'(ipl) < int'(SW_W) - 1) begin
      for (int i = 0; i < int'(SW_W); i++) begin
        if (sum[i] && (i > int'(ipl))) sw_pick = LVL_W'(i);
      end
    end
  endfunction
endpackage

// File: rtl/intr_req_bank.sv
module intr_req_bank
  import intr_pkg::*;
#(
  parameter int unsigned BANK_SRCS = SRCS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [BANK_SRCS-1:0] set_pulse,
  input  logic                 ack_hit,
  output logic [SRC_W-1:0]     low_idx,
  output logic                 any
);
  logic [BANK_SRCS-1:0] pend;
  logic [BANK_SRCS-1:0] clr_mask;

  assign any      = |pend;
  assign low_idx  = lowest_src(pend);
  assign clr_mask = (ack_hit && any) ? (BANK_SRCS'(1) << low_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_mask) | set_pulse;
  end

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_pulse != '0) |=> ((pend & $past(set_pulse)) == $past(set_pulse)));

  assert_ack_clears_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && any && set_pulse == '0) |=>
      ($countones(pend) + 1 == $countones($past(pend))));

  assert_empty_ack_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !any && set_pulse == '0) |=> $stable(pend));
endmodule

// File: rtl/intr_vec_table.sv
module intr_vec_table
  import intr_pkg::*;
#(
  parameter int unsigned TBL_LVLS = NUM_HW,
  parameter int unsigned TBL_SRCS = SRCS,
  parameter int unsigned TBL_W    = VEC_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [HW_IDX_W-1:0] wlvl,
  input  logic [SRC_W-1:0]    wsrc,
  input  logic [TBL_W-1:0]    wdata,
  input  logic [HW_IDX_W-1:0] rlvl,
  input  logic [SRC_W-1:0]    rsrc,
  output logic [TBL_W-1:0]    rdata
);
  localparam int unsigned DEPTH = TBL_LVLS * TBL_SRCS;

  logic [TBL_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
    end else if (we) begin
      mem[{wlvl, wsrc}] <= wdata;
    end
  end

  assign rdata = mem[{rlvl, rsrc}];

  assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past({wlvl, wsrc})] == $past(wdata)));
endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter
  import intr_pkg::*;
#(
  parameter int unsigned ARB_HW = NUM_HW
) (
  input  logic [LVL_W-1:0]  ipl,
  input  logic              halt,
  input  logic              merr,
  input  logic [ARB_HW-1:0] busy,
  input  logic [SW_W-1:0]   sw_sum,
  output logic [LVL_W-1:0]  win
);
  logic             done;
  logic [LVL_W-1:0] lvl;

  always_comb begin
    win  = '0;
    done = 1'b0;
    lvl  = '0;
    if (halt) begin
      win = LVL_HALT;
    end else if (merr && (ipl < LVL_MERR)) begin
      win = LVL_MERR;
    end else begin
      for (int k = int'(ARB_HW) - 1; k >= 0; k--) begin
        lvl = LVL_HW_BASE + LVL_W'(k);
        if (!done) begin
          if (lvl <= ipl) begin
            done = 1'b1;
          end else if (busy[k]) begin
            win  = lvl;
            done = 1'b1;
          end
        end
      end
      if (!done) win = sw_pick(ipl, sw_sum);
    end
  end
endmodule

// File: rtl/intr_prio_eval.sv
module intr_prio_eval
  import intr_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LVL_W-1:0]         cur_ipl,
  input  logic                     halt_pin,
  input  logic                     mem_err,
  input  logic [SW_W-1:0]          sw_summary,
  input  logic [NUM_HW*SRCS-1:0]   req_set,
  input  logic                     vec_we,
  input  logic [HW_IDX_W-1:0]      vec_lvl,
  input  logic [SRC_W-1:0]         vec_src,
  input  logic [VEC_W-1:0]         vec_wdata,
  input  logic                     ack_valid,
  input  logic [HW_IDX_W-1:0]      ack_lvl,
  output logic [LVL_W-1:0]         win_level,
  output logic                     ack_ready,
  output logic [VEC_W-1:0]         ack_vector
);
  logic [NUM_HW-1:0] lvl_busy;
  logic [NUM_HW-1:0] ack_hit;
  logic [SRC_W-1:0]  low_idx_w [NUM_HW];
  logic              sel_any;
  logic [SRC_W-1:0]  sel_idx;
  logic [VEC_W-1:0]  sel_vec;

  for (genvar k = 0; k < int'(NUM_HW); k++) begin : g_lvl
    assign ack_hit[k] = ack_valid && (ack_lvl == HW_IDX_W'(k));
    intr_req_bank #(.BANK_SRCS(SRCS)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_pulse(req_set[k*SRCS +: SRCS]),
      .ack_hit  (ack_hit[k]),
      .low_idx  (low_idx_w[k]),
      .any      (lvl_busy[k])
    );
  end

  assign sel_any = lvl_busy[ack_lvl];
  assign sel_idx = low_idx_w[ack_lvl];

  intr_vec_table #(.TBL_LVLS(NUM_HW), .TBL_SRCS(SRCS), .TBL_W(VEC_W)) u_vtab (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (vec_we),
    .wlvl (vec_lvl),
    .wsrc (vec_src),
    .wdata(vec_wdata),
    .rlvl (ack_lvl),
    .rsrc (sel_idx),
    .rdata(sel_vec)
  );

  intr_arbiter #(.ARB_HW(NUM_HW)) u_arb (
    .ipl   (cur_ipl),
    .halt  (halt_pin),
    .merr  (mem_err),
    .busy  (lvl_busy),
    .sw_sum(sw_summary),
    .win   (win_level)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_ready  <= 1'b0;
      ack_vector <= '0;
    end else begin
      ack_ready  <= ack_valid;
      ack_vector <= (ack_valid && sel_any) ? sel_vec : '0;
    end
  end

  assert_halt_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    halt_pin |-> (win_level == LVL_HALT));

  assert_merr_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_pin && mem_err && (cur_ipl < LVL_MERR)) |-> (win_level == LVL_MERR));

  assert_above_ipl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_pin && (win_level != '0)) |-> (win_level > cur_ipl));

  assert_sw_cut_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_pin && !mem_err && (lvl_busy == '0) && (cur_ipl >= LVL_W'(SW_W - 1)))
      |-> (win_level == '0));

  assert_ack_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> ack_ready);

  assert_empty_vec_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !sel_any) |=> (ack_vector == '0));
endmodule

// File: tb/tb_intr_prio_eval.sv
module tb_intr_prio_eval;
  import intr_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                   rst_n = 1'b0;
  logic [LVL_W-1:0]       cur_ipl = '0;
  logic                   halt_pin = 1'b0, mem_err = 1'b0;
  logic [SW_W-1:0]        sw_summary = '0;
  logic [NUM_HW*SRCS-1:0] req_set = '0;
  logic                   vec_we = 1'b0;
  logic [HW_IDX_W-1:0]    vec_lvl = '0;
  logic [SRC_W-1:0]       vec_src = '0;
  logic [VEC_W-1:0]       vec_wdata = '0;
  logic                   ack_valid = 1'b0;
  logic [HW_IDX_W-1:0]    ack_lvl = '0;
  logic [LVL_W-1:0]       win_level;
  logic                   ack_ready;
  logic [VEC_W-1:0]       ack_vector;

  intr_prio_eval dut (.*);

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] pend_m [4];
  logic [15:0] vec_m  [4][32];
  logic [15:0] exp_q [$];
  string       tag_q [$];

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic win_case(input logic [4:0] ipl, input logic h, input logic m,
                          input logic [15:0] sw, input int exp, input string tag);
    @(negedge clk);
    cur_ipl = ipl; halt_pin = h; mem_err = m; sw_summary = sw;
    #1 chk(win_level, exp, tag);
  endtask

  task automatic set_src(input int l, input int s);
    @(negedge clk);
    req_set[l*32+s] = 1'b1;
    pend_m[l][s] = 1'b1;
    @(negedge clk);
    req_set = '0;
  endtask

  task automatic wvec(input int l, input int s, input logic [15:0] v);
    @(negedge clk);
    vec_we = 1'b1; vec_lvl = 2'(l); vec_src = 5'(s); vec_wdata = v;
    vec_m[l][s] = v;
    @(negedge clk);
    vec_we = 1'b0;
  endtask

  // driver: acknowledge level l, optionally pulsing source set_s in the same cycle
  task automatic ack(input int l, input int set_s, input string tag);
    int lo;
    @(negedge clk);
    ack_valid = 1'b1; ack_lvl = 2'(l);
    if (set_s >= 0) req_set[l*32+set_s] = 1'b1;
    lo = -1;
    for (int i = 31; i >= 0; i--) if (pend_m[l][i]) lo = i;
    if (lo >= 0) begin
      exp_q.push_back(vec_m[l][lo]);
      pend_m[l][lo] = 1'b0;
    end else begin
      exp_q.push_back(16'h0);
    end
    tag_q.push_back(tag);
    if (set_s >= 0) pend_m[l][set_s] = 1'b1;
    @(negedge clk);
    ack_valid = 1'b0; req_set = '0;
  endtask

  // monitor: compare each acknowledge result with the queued expectation
  always @(negedge clk) begin
    if (rst_n && ack_ready) begin
      if (exp_q.size() == 0) chk(1, 0, "R7 unexpected ack_ready");
      else chk(ack_vector, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < 4; l++) begin
      pend_m[l] = '0;
      for (int s = 0; s < 32; s++) vec_m[l][s] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(win_level, 0, "R6 reset win_level");
    chk(ack_ready, 0, "R10 reset ack_ready");

    for (int l = 0; l < 4; l++)
      for (int s = 0; s < 32; s++) wvec(l, s, 16'(16'h0200 + l*128 + s*4));

    win_case(5'h1F, 1, 0, 16'h0000, 5'h1F, "R1 halt at top ipl");
    win_case(5'h00, 1, 1, 16'hFFFF, 5'h1F, "R1 halt over merr");
    win_case(5'h1C, 0, 1, 16'h0000, 5'h1D, "R2 merr below");
    win_case(5'h1D, 0, 1, 16'h0000, 5'h00, "R2 merr at level");
    win_case(5'h1E, 0, 1, 16'hFFFF, 5'h00, "R2 merr above");
    win_case(5'h00, 0, 0, 16'h0422, 5'h0A, "R5 highest sw");
    win_case(5'h05, 0, 0, 16'h0422, 5'h0A, "R5 sw ipl 5");
    win_case(5'h0A, 0, 0, 16'h0422, 5'h00, "R4 sw masked");
    win_case(5'h0E, 0, 0, 16'h8000, 5'h0F, "R4 sw bit 15");
    win_case(5'h0F, 0, 0, 16'h8000, 5'h00, "R4 sw cutoff");
    win_case(5'h00, 0, 0, 16'h0001, 5'h00, "R4 sw bit 0");
    win_case(5'h00, 0, 0, 16'h0000, 5'h00, "R6 idle");

    set_src(1, 5); set_src(1, 3); set_src(3, 0);
    win_case(5'h00, 0, 0, 16'hFFFF, 5'h17, "R3 top hw");
    win_case(5'h16, 0, 0, 16'h0000, 5'h17, "R3 hw above ipl");
    win_case(5'h17, 0, 0, 16'hFFFF, 5'h00, "R3 hw at ipl");
    win_case(5'h10, 0, 1, 16'h0000, 5'h1D, "R2 merr over hw");

    ack(3, -1, "R7 ack 0x17 src0");
    win_case(5'h00, 0, 0, 16'hFFFF, 5'h15, "R3 next hw");
    win_case(5'h15, 0, 0, 16'hFFFF, 5'h00, "R3 scan stops");
    win_case(5'h14, 0, 0, 16'h0000, 5'h15, "R3 0x15 over 0x14");
    ack(1, -1, "R7 ack 0x15 lowest src3");
    ack(1, -1, "R7 ack 0x15 src5");
    ack(1, -1, "R8 ack empty level");
    win_case(5'h00, 0, 0, 16'h0010, 5'h04, "R4 sw after hw drained");

    set_src(0, 4);
    win_case(5'h14, 0, 0, 16'hFFFF, 5'h00, "R3 0x14 at ipl");
    win_case(5'h13, 0, 0, 16'hFFFF, 5'h14, "R3 0x14 above ipl");
    ack(0, -1, "R7 ack 0x14 src4");

    set_src(2, 7);
    ack(2, 7, "R9 ack with same-bit set");
    win_case(5'h14, 0, 0, 16'h0000, 5'h16, "R9 bit still pending");
    ack(2, -1, "R9 re-set source acked");
    ack(2, -1, "R8 level drained");

    set_src(0, 2);
    ack(0, 9, "R9 ack with other-bit set");
    ack(0, -1, "R9 set source survives");
    win_case(5'h00, 0, 0, 16'h0000, 5'h00, "R6 all drained");

    wvec(0, 31, 16'hBEEF);
    set_src(0, 31); set_src(0, 30);
    ack(0, -1, "R7 lowest of 30,31");
    ack(0, -1, "R10 rewritten vector");

    repeat (3) @(negedge clk);
    chk(exp_q.size(), 0, "R7 scoreboard drained");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule